// File: doc/BRIEF.md
# Dual-Direction Storage Bus Transceiver

This block moves a word between two ports, A and B, through a separate storage path in each direction. Each storage path has three behaviours, chosen by its latch-enable and its data clock. With the latch-enable high, data flows straight through. With the latch-enable low and the data clock steady, the path holds its stored word. With the latch-enable low, a high-to-low transition of the data clock loads a new word. Each direction also has an output enable. The A-to-B enable is active-high and the B-to-A enable is active-low.

The port outputs are synthesizable data/enable pairs, not true tri-state pins. A pad ring or wrapper combines each pair into a tri-state driver. One system clock runs all internal registers. The two data clocks are treated as ordinary inputs. Each is sampled once per system cycle and passed through an edge detector. A captured word therefore appears one system cycle after the sampled falling edge. A disabled output reads as enable low with data forced to zero.

Top module: `dual_store_xcvr`

## Requirements
- R1: While `rstN` is low, `aEn` and `bEn` are 0. At a rising system clock edge with `rstN` low, both storage words are cleared to zero.
- R2: While `leAtoB` is high and `oeAtoB` is high, `bOut` equals `aIn` combinationally, in the same cycle. The word is also written into the A-to-B storage at every system edge.
- R3: While `leAtoB` is low and `clkAtoB` does not change, the stored word and `bOut` stay unchanged, whatever `aIn` does.
- R4: With `leAtoB` low, suppose `clkAtoB` is sampled high at one system edge and low at the next. The A-to-B storage then loads `aIn` at the following edge, and that word drives `bOut`.
- R5: A low-to-high transition of `clkAtoB` with `leAtoB` low does not change the stored word.
- R6: Suppose `clkAtoB` is high when `leAtoB` falls. Its later fall still loads new data. If `clkAtoB` was already low, the path simply holds.
- R7: When `leAtoB` falls, the storage keeps the last word that was passed through transparently.
- R8: `oeAtoB` is active-high. While it is low, `bEn` is 0 and `bOut` is all zeros, and the stored word is kept. Raising it again shows the unchanged stored word.
- R9: The B-to-A path behaves the same way, using `leBtoA`, `clkBtoA`, `bIn`, `aOut` and `aEn`. Its enable `oeBtoAN` is active-low: 0 drives and 1 disables.
- R10: If both directions are enabled at once, both `aEn` and `bEn` are 1 and each port carries its own path's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| aIn | input | WIDTH | Word received on port A |
| aOut | output | WIDTH | Word driven onto port A (zero when disabled) |
| aEn | output | 1 | Drive enable for port A |
| bIn | input | WIDTH | Word received on port B |
| bOut | output | WIDTH | Word driven onto port B (zero when disabled) |
| bEn | output | 1 | Drive enable for port B |
| oeAtoB | input | 1 | A-to-B output enable, active high |
| leAtoB | input | 1 | A-to-B latch-enable (high = transparent) |
| clkAtoB | input | 1 | A-to-B data clock, captures on falling edge |
| oeBtoAN | input | 1 | B-to-A output enable, active low |
| leBtoA | input | 1 | B-to-A latch-enable (high = transparent) |
| clkBtoA | input | 1 | B-to-A data clock, captures on falling edge |

## Verification
Transparent data and enable gating are combinational. The bench checks them one nanosecond after the inputs change, with no clock edge in between. A data-clock fall needs two system edges before the output shows the new word: one edge samples the low clock, and the next loads the storage. Every table vector therefore waits two full system cycles before it samples. Hold and disable checks use the same two-cycle wait, so any unwanted load would already be visible.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from one direction's control to its datapath.
  typedef struct packed {
    logic follow;   // transparent: pass input and track it into storage
    logic capture;  // load storage on a data-clock falling edge
    logic drive;    // output enable after polarity and reset
  } xfer_strobe_t;
endpackage

// File: rtl/path_ctrl.sv
module path_ctrl
  import xcvr_pkg::*;
#(
  parameter bit OE_ACTIVE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         oeIn,
  input  logic         leIn,
  input  logic         portClk,
  output xfer_strobe_t strobe
);
  logic clkQ;
  logic clkPrev;
  logic fallSeen;
  logic oeActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ    <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      clkQ    <= portClk;
      clkPrev <= clkQ;
    end
  end

  assign fallSeen = clkPrev & ~clkQ;

  generate
    if (OE_ACTIVE_HIGH) begin : g_oeHigh
      assign oeActive = oeIn;
    end else begin : g_oeLow
      assign oeActive = ~oeIn;
    end
  endgenerate

  always_comb begin
    strobe.follow  = leIn;
    strobe.capture = fallSeen & ~leIn & rstN;
    strobe.drive   = oeActive & rstN;
  end

  // A capture strobe only follows a sampled high-then-low data clock.
  assert_capture_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (!$past(portClk) && $past(portClk, 2)));

  // A rising data clock never produces a capture on the next cycle.
  assert_no_rise_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(portClk) && portClk) |=> !strobe.capture);
endmodule

// File: rtl/path_store.sv
module path_store
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  xfer_strobe_t     strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             outEn
);
  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [WIDTH-1:0] store;
  logic [WIDTH-1:0] selWord;
  logic             loadNow;

  assign loadNow = strobe.follow | strobe.capture;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      store <= ZERO_WORD;
    end else if (loadNow) begin
      store <= dataIn;
    end
  end

  assign selWord = strobe.follow ? dataIn : store;
  assign dataOut = strobe.drive ? selWord : ZERO_WORD;
  assign outEn   = strobe.drive;

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rstN |=> (store == ZERO_WORD));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.follow && !strobe.capture) |=> $stable(store));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (store == $past(dataIn)));

  assert_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.follow |=> (store == $past(dataIn)));
endmodule

// File: rtl/dual_store_xcvr.sv
module dual_store_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aEn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bEn,
  input  logic             oeAtoB,
  input  logic             leAtoB,
  input  logic             clkAtoB,
  input  logic             oeBtoAN,
  input  logic             leBtoA,
  input  logic             clkBtoA
);
  xfer_strobe_t abStrobe;
  xfer_strobe_t baStrobe;

  path_ctrl #(.OE_ACTIVE_HIGH(1'b1)) uAbCtrl (
    .clk(clk), .rstN(rstN), .oeIn(oeAtoB), .leIn(leAtoB),
    .portClk(clkAtoB), .strobe(abStrobe)
  );

  path_store #(.WIDTH(WIDTH)) uAbStore (
    .clk(clk), .rstN(rstN), .strobe(abStrobe), .dataIn(aIn),
    .dataOut(bOut), .outEn(bEn)
  );

  path_ctrl #(.OE_ACTIVE_HIGH(1'b0)) uBaCtrl (
    .clk(clk), .rstN(rstN), .oeIn(oeBtoAN), .leIn(leBtoA),
    .portClk(clkBtoA), .strobe(baStrobe)
  );

  path_store #(.WIDTH(WIDTH)) uBaStore (
    .clk(clk), .rstN(rstN), .strobe(baStrobe), .dataIn(bIn),
    .dataOut(aOut), .outEn(aEn)
  );

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rstN |-> (!aEn && !bEn));

  assert_b_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !oeAtoB |-> (!bEn && bOut == '0));

  assert_a_gate_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    oeBtoAN |-> (!aEn && aOut == '0));

  assert_both_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    (oeAtoB && !oeBtoAN) |-> (aEn && bEn));
endmodule

// File: tb/dual_store_xcvr_test.sv
module dual_store_xcvr_test;
  localparam int W = 18;

  typedef struct packed {
    logic         oe;
    logic         le;
    logic         ck;
    logic [W-1:0] a;
    logic [W-1:0] expB;
    logic         expEn;
    logic [3:0]   req;
  } vec_t;

  // Each vector: drive A-to-B controls, wait two system cycles, check B.
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 18'h12345, 18'h12345, 1'b1, 4'd2},  // R2
    '{1'b1, 1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b1, 4'd2},  // R2
    '{1'b1, 1'b0, 1'b0, 18'h00F0F, 18'h2AAAA, 1'b1, 4'd7},  // R7
    '{1'b1, 1'b0, 1'b1, 18'h11111, 18'h2AAAA, 1'b1, 4'd5},  // R5
    '{1'b1, 1'b0, 1'b0, 18'h11111, 18'h11111, 1'b1, 4'd4},  // R4
    '{1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h11111, 1'b1, 4'd3},  // R3
    '{1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h00000, 1'b0, 4'd8},  // R8
    '{1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h11111, 1'b1, 4'd8},  // R8
    '{1'b1, 1'b1, 1'b1, 18'h05555, 18'h05555, 1'b1, 4'd2},  // R2
    '{1'b1, 1'b0, 1'b1, 18'h05555, 18'h05555, 1'b1, 4'd6},  // R6
    '{1'b1, 1'b0, 1'b1, 18'h0ABCD, 18'h05555, 1'b1, 4'd6},  // R6
    '{1'b1, 1'b0, 1'b0, 18'h0ABCD, 18'h0ABCD, 1'b1, 4'd6}   // R6
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic         aEn, bEn;
  logic         oeAtoB = 1'b1, leAtoB = 1'b1, clkAtoB = 1'b0;
  logic         oeBtoAN = 1'b0, leBtoA = 1'b1, clkBtoA = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_store_xcvr #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN),
    .aIn(aIn), .aOut(aOut), .aEn(aEn),
    .bIn(bIn), .bOut(bOut), .bEn(bEn),
    .oeAtoB(oeAtoB), .leAtoB(leAtoB), .clkAtoB(clkAtoB),
    .oeBtoAN(oeBtoAN), .leBtoA(leBtoA), .clkBtoA(clkBtoA)
  );

  task automatic check(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Move to just after a falling edge, where inputs are changed.
  task automatic toNeg();
    @(negedge clk);
  endtask

  task automatic waitTwo();
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset holds both enables low although both are commanded on
    toNeg();
    #1;
    check("R1 bEn in reset", {17'd0, bEn}, 18'd0);
    check("R1 aEn in reset", {17'd0, aEn}, 18'd0);
    aIn = 18'h3C3C3;
    bIn = 18'h0F0F0;
    waitTwo();
    check("R1 bEn held low", {17'd0, bEn}, 18'd0);
    // Leave reset in hold mode: stored words must be zero
    toNeg();
    leAtoB = 1'b0;
    leBtoA = 1'b0;
    rstN = 1'b1;
    waitTwo();
    check("R1 B store zero", bOut, 18'd0);
    check("R1 A store zero", aOut, 18'd0);

    // Table walk over the A-to-B path
    for (int i = 0; i < NV; i++) begin
      toNeg();
      oeAtoB  = VECS[i].oe;
      leAtoB  = VECS[i].le;
      clkAtoB = VECS[i].ck;
      aIn     = VECS[i].a;
      waitTwo();
      check($sformatf("R%0d vec%0d bOut", VECS[i].req, i), bOut, VECS[i].expB);
      check($sformatf("R%0d vec%0d bEn", VECS[i].req, i), {17'd0, bEn},
            {17'd0, VECS[i].expEn});
    end

    // R2: transparency is combinational, no edge needed
    toNeg();
    leAtoB = 1'b1;
    aIn = 18'h1ACE5;
    #1;
    check("R2 same-cycle follow", bOut, 18'h1ACE5);

    // R6: clock already low when the latch-enable falls -> hold
    toNeg();
    clkAtoB = 1'b0;
    waitTwo();
    toNeg();
    leAtoB = 1'b0;
    waitTwo();
    toNeg();
    aIn = 18'h02222;
    waitTwo();
    check("R6 low clock holds", bOut, 18'h1ACE5);

    // R9: B-to-A path, active-low enable, fall capture
    toNeg();
    oeBtoAN = 1'b0;
    leBtoA = 1'b0;
    clkBtoA = 1'b1;
    bIn = 18'h1F00F;
    waitTwo();
    check("R9 A before fall", aOut, 18'h00000);
    toNeg();
    clkBtoA = 1'b0;
    waitTwo();
    check("R9 A captured", aOut, 18'h1F00F);
    toNeg();
    oeBtoAN = 1'b1;
    #1;
    check("R9 aEn off when high", {17'd0, aEn}, 18'd0);
    check("R9 aOut zero when off", aOut, 18'd0);
    toNeg();
    oeBtoAN = 1'b0;
    leBtoA = 1'b1;
    bIn = 18'h2BEEF;
    #1;
    check("R9 A transparent", aOut, 18'h2BEEF);

    // R10: both directions enabled together
    toNeg();
    oeAtoB = 1'b1;
    oeBtoAN = 1'b0;
    waitTwo();
    check("R10 aEn", {17'd0, aEn}, 18'd1);
    check("R10 bEn", {17'd0, bEn}, 18'd1);
    check("R10 bOut", bOut, 18'h1ACE5);
    check("R10 aOut", aOut, 18'h2BEEF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule